// File: doc/BRIEF.md
# Serial Controller Configuration Front End

This block is the processor-side register interface of a programmable serial controller that runs either asynchronously or with sync characters. It decodes an active-low chip select, active-low read and write strobes and a control/data select line on an 8-bit bus. Writes to the control port are steered by a sequencer. The first write after any reset sets the operating mode. In synchronous mode, one or two sync-character writes follow. Every later control write is a command, until a command requests an internal reset and the sequence starts over.

Reads of the control port return a status byte. This byte combines ready and empty indications from the shifters, three sticky error flags held in this block, a sync-detect indication and the modem data-set-ready input. Reads of the data port return the received character and pulse a consume strobe to the receiver. Writes to the data port hand one character to the transmitter. The decoded mode fields and the command bits drive the transmitter and receiver, which sit outside this block.

Top module: `sercfg_front`

## Requirements
- R1: While and after the external reset (active high, synchronous), the sequencer waits for a mode byte, `tx_en` and `rx_en` are 0, `dtr_n` and `rts_n` are 1, all error flags are 0 and `dout` is 0.
- R2: The first control write (`cd`=1) after a reset is stored as the mode byte and decoded as follows. Bits [1:0] give `baud_sel` (00 means synchronous, 01 means x1, 10 means x16, 11 means x64), and `is_sync` is 1 exactly when they are 00. Bits [3:2] give `char_len` (00 = 5 bits to 11 = 8 bits). Bit 4 gives `par_en`, bit 5 gives `par_even` and bits [7:6] give `stop_sel`. Bit 7 also gives `sync_single`.
- R3: In synchronous mode, the control writes that follow the mode byte go to `sync1` and then `sync2`, or to `sync1` alone when `sync_single` is 1. These writes leave the command outputs unchanged. The next control write is a command.
- R4: In asynchronous mode, the control write that follows the mode byte is already a command.
- R5: Each command write sets the command outputs: bit 0 sets `tx_en`, bit 2 sets `rx_en`, bit 1 drives `dtr_n` low when 1, and bit 5 drives `rts_n` low when 1. Every further control write is also a command, and the mode outputs stay unchanged.
- R6: A command with bit 6 set clears `tx_en` and `rx_en`, raises `dtr_n` and `rts_n`, and clears the error flags. The next control write is then taken as a mode byte.
- R7: One-cycle pulses on `pe_set`, `oe_set` or `fe_set` set sticky parity, overrun and framing flags. A command with bit 4 set clears all three flags.
- R8: A read with `cd`=1 gives, one clock after the strobe becomes active, the status byte on `dout`. From bit 7 down to bit 0 the byte is {`dsr`, `sync_det`, FE, OE, PE, `tx_empty`, `rx_rdy`, `tx_rdy`}.
- R9: A read with `cd`=0 gives `rx_data` on `dout` and pulses `rx_rd` for exactly one cycle per read strobe.
- R10: A write with `cd`=0 pulses `tx_wr` for exactly one cycle per strobe, with `tx_data` holding the written byte. It does not advance the sequencer.
- R11: While `cs_n` is 1, read and write strobes have no effect on any output.
- R12: An external reset in the middle of a sequence makes the next control write a mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External reset, active high, synchronous |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| din | input | BUS_W | Write data bus |
| dout | output | BUS_W | Read data bus, registered, 0 when idle |
| tx_rdy | input | 1 | Transmitter can take a character |
| rx_rdy | input | 1 | Receiver holds a character |
| tx_empty | input | 1 | Transmitter fully drained |
| sync_det | input | 1 | Sync pattern detected |
| dsr | input | 1 | Data-set-ready level |
| rx_data | input | BUS_W | Received character |
| pe_set | input | 1 | Parity error pulse |
| oe_set | input | 1 | Overrun error pulse |
| fe_set | input | 1 | Framing error pulse |
| tx_wr | output | 1 | One-cycle load strobe to transmitter |
| tx_data | output | BUS_W | Character for transmitter |
| rx_rd | output | 1 | One-cycle consume strobe to receiver |
| is_sync | output | 1 | Synchronous mode selected |
| baud_sel | output | 2 | Baud factor code |
| char_len | output | 2 | Character length code |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity |
| stop_sel | output | 2 | Stop bit code |
| sync_single | output | 1 | One sync character |
| sync1 | output | BUS_W | First sync character |
| sync2 | output | BUS_W | Second sync character |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| err_clr | output | 1 | Pulse when an error-reset command is taken |
| int_rst | output | 1 | Pulse when an internal-reset command is taken |

## Verification
The bench builds the block with the default `BUS_W` of 8. At this width every mode field, every command bit and all eight status positions fall on real bus lines, so each field decode and each status position can be checked on its own. The directed scenarios walk every path of the sequencer: the asynchronous path, the synchronous path with two sync characters and with one, an internal reset and an external reset taken part-way through a sequence. In each case the bench watches whether a byte with bit 0 set enables the transmitter, which shows whether that byte was taken as a command.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  typedef enum logic [1:0] {
    PH_MODE  = 2'd0,
    PH_SYNC1 = 2'd1,
    PH_SYNC2 = 2'd2,
    PH_CMD   = 2'd3
  } phase_e;

  localparam int CB_TXEN   = 0;
  localparam int CB_DTR    = 1;
  localparam int CB_RXEN   = 2;
  localparam int CB_ERRCLR = 4;
  localparam int CB_RTS    = 5;
  localparam int CB_IRST   = 6;
  localparam int MB_SSYNC  = 7;
  localparam int NUM_ERR   = 3;
  localparam int STAT_W    = 8;
endpackage

// File: rtl/sercfg_strobe.sv
module sercfg_strobe (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic stb_n,
  output logic act,
  output logic pulse
);
  logic act_q;

  assign act   = !sel_n && !stb_n;
  assign pulse = act && !act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end
endmodule

// File: rtl/sercfg_errs.sv
module sercfg_errs #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         flag[i] <= 1'b0;
        else if (set[i]) flag[i] <= 1'b1;
        else if (clr)    flag[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/sercfg_seq.sv
module sercfg_seq
  import sercfg_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic [BUS_W-1:0] din,
  output phase_e           phase,
  output logic [BUS_W-1:0] mode_q,
  output logic [BUS_W-1:0] sync1_q,
  output logic [BUS_W-1:0] sync2_q,
  output logic             tx_en,
  output logic             rx_en,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             err_clr,
  output logic             int_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_MODE;
      mode_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      dtr_n   <= 1'b1;
      rts_n   <= 1'b1;
      err_clr <= 1'b0;
      int_rst <= 1'b0;
    end else begin
      err_clr <= 1'b0;
      int_rst <= 1'b0;
      if (wr_ctl) begin
        case (phase)
          PH_MODE: begin
            mode_q <= din;
            phase  <= (din[1:0] == 2'b00) ? PH_SYNC1 : PH_CMD;
          end
          PH_SYNC1: begin
            sync1_q <= din;
            phase   <= mode_q[MB_SSYNC] ? PH_CMD : PH_SYNC2;
          end
          PH_SYNC2: begin
            sync2_q <= din;
            phase   <= PH_CMD;
          end
          default: begin
            if (din[CB_IRST]) begin
              phase   <= PH_MODE;
              tx_en   <= 1'b0;
              rx_en   <= 1'b0;
              dtr_n   <= 1'b1;
              rts_n   <= 1'b1;
              err_clr <= 1'b1;
              int_rst <= 1'b1;
            end else begin
              tx_en   <= din[CB_TXEN];
              rx_en   <= din[CB_RXEN];
              dtr_n   <= !din[CB_DTR];
              rts_n   <= !din[CB_RTS];
              err_clr <= din[CB_ERRCLR];
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sercfg_front.sv
module sercfg_front
  import sercfg_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             cd,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  input  logic             tx_rdy,
  input  logic             rx_rdy,
  input  logic             tx_empty,
  input  logic             sync_det,
  input  logic             dsr,
  input  logic [BUS_W-1:0] rx_data,
  input  logic             pe_set,
  input  logic             oe_set,
  input  logic             fe_set,
  output logic             tx_wr,
  output logic [BUS_W-1:0] tx_data,
  output logic             rx_rd,
  output logic             is_sync,
  output logic [1:0]       baud_sel,
  output logic [1:0]       char_len,
  output logic             par_en,
  output logic             par_even,
  output logic [1:0]       stop_sel,
  output logic             sync_single,
  output logic [BUS_W-1:0] sync1,
  output logic [BUS_W-1:0] sync2,
  output logic             tx_en,
  output logic             rx_en,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             err_clr,
  output logic             int_rst
);
  logic wr_act, wr_pulse, rd_act, rd_pulse;
  logic wr_ctl;
  phase_e phase;
  logic [BUS_W-1:0]   mode_q;
  logic [NUM_ERR-1:0] err_flag;
  logic [STAT_W-1:0]  status;

  sercfg_strobe u_wr (.clk(clk), .rst(rst), .sel_n(cs_n), .stb_n(wr_n),
                      .act(wr_act), .pulse(wr_pulse));
  sercfg_strobe u_rd (.clk(clk), .rst(rst), .sel_n(cs_n), .stb_n(rd_n),
                      .act(rd_act), .pulse(rd_pulse));

  assign wr_ctl = wr_pulse && cd;

  sercfg_seq #(.BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .din(din),
    .phase(phase), .mode_q(mode_q), .sync1_q(sync1), .sync2_q(sync2),
    .tx_en(tx_en), .rx_en(rx_en), .dtr_n(dtr_n), .rts_n(rts_n),
    .err_clr(err_clr), .int_rst(int_rst)
  );

  sercfg_errs #(.N(NUM_ERR)) u_errs (
    .clk(clk), .rst(rst), .clr(err_clr),
    .set({fe_set, oe_set, pe_set}), .flag(err_flag)
  );

  assign status = {dsr, sync_det, err_flag[2], err_flag[1], err_flag[0],
                   tx_empty, rx_rdy, tx_rdy};

  assign baud_sel    = mode_q[1:0];
  assign is_sync     = (mode_q[1:0] == 2'b00);
  assign char_len    = mode_q[3:2];
  assign par_en      = mode_q[4];
  assign par_even    = mode_q[5];
  assign stop_sel    = mode_q[7:6];
  assign sync_single = mode_q[MB_SSYNC];

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      tx_wr   <= 1'b0;
      tx_data <= '0;
      rx_rd   <= 1'b0;
    end else begin
      if (rd_act) dout <= cd ? BUS_W'(status) : rx_data;
      else        dout <= '0;
      tx_wr <= wr_pulse && !cd;
      if (wr_pulse && !cd) tx_data <= din;
      rx_rd <= rd_pulse && !cd;
    end
  end
endmodule

// File: rtl/sercfg_front_chk.sv
module sercfg_front_chk
  import sercfg_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input phase_e           phase,
  input logic [BUS_W-1:0] mode_q,
  input logic             tx_en,
  input logic             rx_en,
  input logic             dtr_n,
  input logic             rts_n,
  input logic             int_rst,
  input logic             tx_wr,
  input logic             rx_rd
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase == PH_MODE && dtr_n && rts_n && !tx_en && !rx_en));

  p_mode_only_first_r2: assert property (@(posedge clk) disable iff (rst)
    (seen && mode_q != $past(mode_q)) |-> ($past(phase) == PH_MODE));

  p_cmd_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && tx_en != $past(tx_en)) |-> ($past(phase) == PH_CMD));

  p_sync_order_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && phase == PH_SYNC2) |-> ($past(phase) == PH_SYNC1 || $past(phase) == PH_SYNC2));

  p_irst_state_r6: assert property (@(posedge clk) disable iff (rst)
    int_rst |-> (phase == PH_MODE && dtr_n && rts_n && !tx_en && !rx_en));

  p_txwr_single_r10: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_wr);

  p_rxrd_single_r9: assert property (@(posedge clk) disable iff (rst)
    rx_rd |=> !rx_rd);
endmodule

bind sercfg_front sercfg_front_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .mode_q(mode_q),
  .tx_en(tx_en), .rx_en(rx_en), .dtr_n(dtr_n), .rts_n(rts_n),
  .int_rst(int_rst), .tx_wr(tx_wr), .rx_rd(rx_rd)
);

// File: tb/sercfg_front_test.sv
module sercfg_front_test;
  localparam int BUS_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic [BUS_W-1:0] din = '0, rx_data = '0;
  logic tx_rdy = 0, rx_rdy = 0, tx_empty = 0, sync_det = 0, dsr = 0;
  logic pe_set = 0, oe_set = 0, fe_set = 0;
  logic [BUS_W-1:0] dout, tx_data, sync1, sync2;
  logic tx_wr, rx_rd, is_sync, par_en, par_even, sync_single;
  logic [1:0] baud_sel, char_len, stop_sel;
  logic tx_en, rx_en, dtr_n, rts_n, err_clr, int_rst;

  int n_chk = 0, n_fail = 0;
  logic w1, w2, r1, r2;
  logic [BUS_W-1:0] wd, d1;

  always #5 clk = ~clk;

  sercfg_front #(.BUS_W(BUS_W)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel_n, input logic c, input logic [7:0] v);
    @(negedge clk); cs_n = sel_n; wr_n = 1'b0; cd = c; din = v;
    @(negedge clk); w1 = tx_wr; wd = tx_data;
    @(negedge clk); w2 = tx_wr; cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic sel_n, input logic c);
    @(negedge clk); cs_n = sel_n; rd_n = 1'b0; cd = c;
    @(negedge clk); d1 = dout; r1 = rx_rd;
    @(negedge clk); r2 = rx_rd; cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_err(input logic [2:0] m);
    @(negedge clk); {fe_set, oe_set, pe_set} = m;
    @(negedge clk); {fe_set, oe_set, pe_set} = 3'b000;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 dtr_n/rts_n", {dtr_n, rts_n}, 2'b11);
    chk("R1 dout", dout, 0);
    rst = 1'b0;
    @(negedge clk);
    tx_rdy = 1; tx_empty = 1; dsr = 1;
    rd(1'b0, 1'b1);
    chk("R1 error flags clear", d1[5:3], 3'b000);
  endtask

  task automatic t_async;
    wr(1'b0, 1'b1, 8'hFE);
    chk("R2 baud_sel", baud_sel, 2'b10);
    chk("R2 is_sync", is_sync, 0);
    chk("R2 char_len", char_len, 2'b11);
    chk("R2 parity", {par_en, par_even}, 2'b11);
    chk("R2 stop_sel", stop_sel, 2'b11);
    wr(1'b0, 1'b1, 8'h23);
    chk("R4 first write after async mode is command", tx_en, 1);
    chk("R5 dtr_n/rts_n low", {dtr_n, rts_n}, 2'b00);
    chk("R5 rx_en", rx_en, 0);
    wr(1'b0, 1'b1, 8'h04);
    chk("R5 second command", {tx_en, rx_en, dtr_n, rts_n}, 4'b0111);
    chk("R5 mode unchanged", {stop_sel, par_even, par_en, char_len, baud_sel}, 8'hFE);
  endtask

  task automatic t_data;
    wr(1'b0, 1'b0, 8'hA5);
    chk("R10 tx_wr pulse", {w1, w2}, 2'b10);
    chk("R10 tx_data", wd, 8'hA5);
    chk("R10 sequencer untouched", {tx_en, rx_en}, 2'b01);
    rx_data = 8'h3C;
    rd(1'b0, 1'b0);
    chk("R9 dout rx_data", d1, 8'h3C);
    chk("R9 rx_rd single pulse", {r1, r2}, 2'b10);
  endtask

  task automatic t_status;
    pulse_err(3'b101);
    rd(1'b0, 1'b1);
    chk("R8 R7 status with PE FE", d1, 8'hAD);
    wr(1'b0, 1'b1, 8'h10);
    rd(1'b0, 1'b1);
    chk("R7 error reset clears flags", d1, 8'h85);
  endtask

  task automatic t_cs;
    wr(1'b1, 1'b1, 8'h01);
    chk("R11 control write ignored", tx_en, 0);
    wr(1'b1, 1'b0, 8'h55);
    chk("R11 data write ignored", {w1, w2}, 2'b00);
    rd(1'b1, 1'b1);
    chk("R11 read ignored", d1, 8'h00);
  endtask

  task automatic t_irst;
    wr(1'b0, 1'b1, 8'h23);
    pulse_err(3'b010);
    wr(1'b0, 1'b1, 8'h40);
    chk("R6 outputs inactive", {tx_en, rx_en, dtr_n, rts_n}, 4'b0011);
    rd(1'b0, 1'b1);
    chk("R6 flags cleared", d1[5:3], 3'b000);
    wr(1'b0, 1'b1, 8'h4D);
    chk("R6 next write is mode", {stop_sel, baud_sel, char_len}, 6'b010111);
    chk("R6 mode byte not a command", tx_en, 0);
  endtask

  task automatic t_sync_two;
    wr(1'b0, 1'b1, 8'h40);
    wr(1'b0, 1'b1, 8'h0C);
    chk("R2 sync mode", {is_sync, sync_single}, 2'b10);
    wr(1'b0, 1'b1, 8'h17);
    chk("R3 sync1", sync1, 8'h17);
    chk("R3 sync char not command", tx_en, 0);
    wr(1'b0, 1'b1, 8'h35);
    chk("R3 sync2", sync2, 8'h35);
    chk("R3 second sync not command", tx_en, 0);
    wr(1'b0, 1'b1, 8'h01);
    chk("R3 command after two syncs", tx_en, 1);
  endtask

  task automatic t_sync_one;
    wr(1'b0, 1'b1, 8'h40);
    wr(1'b0, 1'b1, 8'h8C);
    chk("R2 sync_single", sync_single, 1);
    wr(1'b0, 1'b1, 8'h96);
    chk("R3 single sync1", sync1, 8'h96);
    chk("R3 sync2 kept", sync2, 8'h35);
    wr(1'b0, 1'b1, 8'h05);
    chk("R3 command after one sync", {tx_en, rx_en}, 2'b11);
  endtask

  task automatic t_ext_reset;
    wr(1'b0, 1'b1, 8'h40);
    wr(1'b0, 1'b1, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(1'b0, 1'b1, 8'h4E);
    chk("R12 write after reset is mode", {is_sync, baud_sel}, 3'b010);
    wr(1'b0, 1'b1, 8'h01);
    chk("R12 then command", tx_en, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_async();
    t_data();
    t_status();
    t_cs();
    t_irst();
    t_sync_two();
    t_sync_one();
    t_ext_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule